// File: doc/BRIEF.md
# Line-Written Brightness Matrix Controller

This block is an output device on a processor's byte-wide I/O path. It drives a 5 by 5 grid of lights. Each light has a 4-bit brightness level. The processor first selects the device by number. Selecting it homes a write cursor to the first column of the top line. Each byte written after that sets one light and moves the cursor one column to the right. A next-line strobe moves the cursor to the start of the following line, and after the last line it returns to the top line.

The block holds one brightness level per cell. A free-running phase counter compares each level against the phase, which gives every light a pulse-width-modulated on/off output. Selecting any other device number disconnects the block from the I/O strobes until it is selected again. The stored picture and the light outputs carry on unchanged while it is disconnected.

Top module: `led_matrix_ctrl`

## Requirements
- R1: After reset every cell level is 0, every light output is low, and the block is not selected. A byte write or next-line strobe given before the first select has no effect on any light.
- R2: A select strobe carrying device number 3 makes the block selected and puts the cursor at line 0, column 0. This holds even if the block was already selected.
- R3: A byte write while selected stores bits 3:0 of the byte as the level of the cell at the cursor and advances the column by one. Bits 7:4 are ignored. The light for line r and column c is bit r*5+c of the light output.
- R4: A next-line strobe while selected sets the column to 0 and advances the line by one. From line 4 it goes back to line 0.
- R5: Once five bytes have been written on a line, further byte writes on that line change no cell until a next-line strobe or a select arrives.
- R6: A select strobe carrying any device number other than 3 deselects the block. While deselected, byte writes and next-line strobes change neither the cells nor the cursor, and the stored levels keep driving the lights.
- R7: Each light is on in a PWM slot when the 4-bit free-running phase is below the cell's level. Over any 16 consecutive cycles a light is on for exactly as many cycles as its level, so level 0 is always dark and level 15 is on in 15 of 16 cycles.
- R8: When strobes coincide in one cycle, only one is acted on, in this priority: select first, then next-line, then byte write. The strobes that lose are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_valid | input | 1 | Device-select strobe, one cycle |
| sel_dev | input | 8 | Device number carried with the select strobe |
| wr_valid | input | 1 | Byte-write strobe, one cycle |
| wr_data | input | 8 | Byte written; bits 3:0 are the brightness level |
| nl_valid | input | 1 | Next-line strobe, one cycle |
| lights | output | 25 | Per-light PWM drive; bit r*5+c is line r, column c |

## Verification
A strobe sampled at a clock edge changes the cursor and the cell level at that same edge. The light output is registered, so it reflects the new level from the following edge onward. The bench therefore waits two cycles after its last strobe. It then counts each light's high samples over 16 falling edges and compares each count with the level its own model predicts. Because the phase counter never stops, any 16-cycle window holds every phase exactly once, and this duty count needs no alignment to the counter.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_SELECT,
    CMD_NEWLINE,
    CMD_WRITE
  } lmd_cmd_e;

  // Line that follows line r in a grid of "lines" lines, wrapping to 0.
  function automatic int unsigned lmd_next_line(input int unsigned r,
                                                input int unsigned lines);
    return (r + 1 >= lines) ? 0 : r + 1;
  endfunction

  // Flat cell number for line r, column c.
  function automatic int unsigned lmd_cell_of(input int unsigned r,
                                              input int unsigned c,
                                              input int unsigned cols);
    return r * cols + c;
  endfunction

  // PWM slot decision: lit while the phase is below the level.
  function automatic logic lmd_lit(input int unsigned level,
                                   input int unsigned phase);
    return phase < level;
  endfunction

endpackage

// File: rtl/lmd_cursor.sv
module lmd_cursor
  import lmd_pkg::*;
#(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int DEV_W  = 8,
  parameter int DEV_ID = 3,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_valid,
  input  logic [DEV_W-1:0] sel_dev,
  input  logic             nl_valid,
  input  logic             wr_valid,
  output logic             active,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic [IDX_W-1:0] store_idx,
  output logic             ev_select,
  output logic             ev_deselect,
  output logic             ev_newline,
  output logic             ev_store
);

  localparam logic [COL_W-1:0] COL_LIM = COL_W'(COLS);
  localparam logic [DEV_W-1:0] MY_DEV  = DEV_W'(DEV_ID);

  lmd_cmd_e cmd;

  always_comb begin
    if (sel_valid)     cmd = CMD_SELECT;
    else if (nl_valid) cmd = CMD_NEWLINE;
    else if (wr_valid) cmd = CMD_WRITE;
    else               cmd = CMD_IDLE;
  end

  assign ev_select   = (cmd == CMD_SELECT) && (sel_dev == MY_DEV);
  assign ev_deselect = (cmd == CMD_SELECT) && (sel_dev != MY_DEV);
  assign ev_newline  = (cmd == CMD_NEWLINE) && active;
  assign ev_store    = (cmd == CMD_WRITE) && active && (col < COL_LIM);
  assign store_idx   = IDX_W'(lmd_cell_of(32'(row), 32'(col), COLS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      row    <= '0;
      col    <= '0;
    end else if (ev_select) begin
      active <= 1'b1;
      row    <= '0;
      col    <= '0;
    end else if (ev_deselect) begin
      active <= 1'b0;
    end else if (ev_newline) begin
      row <= ROW_W'(lmd_next_line(32'(row), ROWS));
      col <= '0;
    end else if (ev_store) begin
      col <= col + 1'b1;
    end
  end

endmodule

// File: rtl/lmd_cell_store.sv
module lmd_cell_store #(
  parameter int CELLS = 25,
  parameter int LVL_W = 4,
  parameter int IDX_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [LVL_W-1:0]       level,
  output logic [CELLS*LVL_W-1:0] levels
);

  for (genvar g = 0; g < CELLS; g++) begin : g_cell
    logic [LVL_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)                            q <= '0;
      else if (we && (idx == IDX_W'(g)))     q <= level;
    end
    assign levels[g*LVL_W +: LVL_W] = q;
  end

endmodule

// File: rtl/lmd_pwm.sv
module lmd_pwm
  import lmd_pkg::*;
#(
  parameter int CELLS = 25,
  parameter int LVL_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [CELLS*LVL_W-1:0] levels,
  output logic [LVL_W-1:0]       phase,
  output logic [CELLS-1:0]       lights
);

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= '0;
    else        phase <= phase + 1'b1;
  end

  for (genvar g = 0; g < CELLS; g++) begin : g_drv
    always_ff @(posedge clk) begin
      if (!rst_n) lights[g] <= 1'b0;
      else        lights[g] <= lmd_lit(32'(levels[g*LVL_W +: LVL_W]), 32'(phase));
    end
  end

endmodule

// File: rtl/led_matrix_ctrl.sv
module led_matrix_ctrl #(
  parameter int ROWS   = 5,
  parameter int COLS   = 5,
  parameter int LVL_W  = 4,
  parameter int DEV_W  = 8,
  parameter int DATA_W = 8,
  parameter int DEV_ID = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [DEV_W-1:0]  sel_dev,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              nl_valid,
  output logic [ROWS*COLS-1:0] lights
);

  localparam int CELLS = ROWS * COLS;
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W = $clog2(COLS + 1);
  localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

  logic                   cur_active;
  logic [ROW_W-1:0]       cur_row;
  logic [COL_W-1:0]       cur_col;
  logic [IDX_W-1:0]       cur_idx;
  logic                   ev_select;
  logic                   ev_deselect;
  logic                   ev_newline;
  logic                   ev_store;
  logic [CELLS*LVL_W-1:0] cell_levels;
  logic [LVL_W-1:0]       pwm_phase;

  lmd_cursor #(
    .ROWS(ROWS), .COLS(COLS), .DEV_W(DEV_W), .DEV_ID(DEV_ID),
    .ROW_W(ROW_W), .COL_W(COL_W), .IDX_W(IDX_W)
  ) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_valid  (sel_valid),
    .sel_dev    (sel_dev),
    .nl_valid   (nl_valid),
    .wr_valid   (wr_valid),
    .active     (cur_active),
    .row        (cur_row),
    .col        (cur_col),
    .store_idx  (cur_idx),
    .ev_select  (ev_select),
    .ev_deselect(ev_deselect),
    .ev_newline (ev_newline),
    .ev_store   (ev_store)
  );

  lmd_cell_store #(.CELLS(CELLS), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_cells (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ev_store),
    .idx   (cur_idx),
    .level (wr_data[LVL_W-1:0]),
    .levels(cell_levels)
  );

  lmd_pwm #(.CELLS(CELLS), .LVL_W(LVL_W)) u_pwm (
    .clk   (clk),
    .rst_n (rst_n),
    .levels(cell_levels),
    .phase (pwm_phase),
    .lights(lights)
  );

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int LVL_W = 4,
  parameter int ROW_W = 3,
  parameter int COL_W = 3
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        sel_valid,
  input logic                        nl_valid,
  input logic                        active,
  input logic [ROW_W-1:0]            row,
  input logic [COL_W-1:0]            col,
  input logic                        ev_select,
  input logic                        ev_newline,
  input logic                        ev_store,
  input logic [ROWS*COLS*LVL_W-1:0]  levels,
  input logic [LVL_W-1:0]            phase,
  input logic [ROWS*COLS-1:0]        lights
);

  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0] COL_LIM  = COL_W'(COLS);
  localparam logic [LVL_W-1:0] TOP_LVL  = '1;

  // R2: a select of this device homes the cursor
  p_select_home_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_select |=> (active && row == '0 && col == '0));

  // R3: a stored byte moves the cursor one column on
  p_store_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_store |=> (col == $past(col) + 1'b1 && row == $past(row)));

  // R4: next-line from the last line returns to the top
  p_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_newline && row == LAST_ROW) |=> (row == '0 && col == '0));

  // R5: the column never passes one beyond the last column
  p_col_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_LIM);

  // R6: while deselected, nothing but a select moves the cursor or the cells
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !sel_valid) |=> ($stable(row) && $stable(col) && $stable(levels)));

  // R7: level 0 keeps light 0 dark
  p_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(levels[LVL_W-1:0]) == '0) |-> !lights[0]);

  // R7: full level lights light 0 in every slot but the last
  p_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(levels[LVL_W-1:0]) == TOP_LVL && $past(phase) != TOP_LVL) |-> lights[0]);

  // R8: a select in the same cycle suppresses next-line and write
  p_select_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (!ev_store && !ev_newline));

  // R8: next-line suppresses a write in the same cycle
  p_newline_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nl_valid |-> !ev_store);

endmodule

bind led_matrix_ctrl lmd_checker #(
  .ROWS(ROWS), .COLS(COLS), .LVL_W(LVL_W), .ROW_W(ROW_W), .COL_W(COL_W)
) u_lmd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_valid (sel_valid),
  .nl_valid  (nl_valid),
  .active    (cur_active),
  .row       (cur_row),
  .col       (cur_col),
  .ev_select (ev_select),
  .ev_newline(ev_newline),
  .ev_store  (ev_store),
  .levels    (cell_levels),
  .phase     (pwm_phase),
  .lights    (lights)
);

// File: tb/tb_led_matrix_ctrl.sv
`timescale 1ns/1ps
module tb_led_matrix_ctrl;

  localparam int NR = 5;
  localparam int NC = 5;
  localparam int NCELL = NR * NC;
  localparam int MY_DEV = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_valid = 1'b0;
  logic [7:0]  sel_dev = '0;
  logic        wr_valid = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        nl_valid = 1'b0;
  logic [NCELL-1:0] lights;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  int m_lvl [NCELL];
  int m_row = 0;
  int m_col = 0;
  bit m_on  = 1'b0;

  always #4 clk = ~clk;

  led_matrix_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_dev(sel_dev),
    .wr_valid(wr_valid), .wr_data(wr_data), .nl_valid(nl_valid), .lights(lights)
  );

  // number of slots out of 16 in which a light with this level is lit
  function automatic int duty_of(input int level);
    int n = 0;
    for (int s = 0; s < 16; s++) if (s < level) n++;
    return n;
  endfunction

  function automatic void model_step(input bit s, input int dev, input bit n,
                                     input bit w, input int data);
    if (s) begin
      if (dev == MY_DEV) begin m_on = 1'b1; m_row = 0; m_col = 0; end
      else m_on = 1'b0;
    end else if (n) begin
      if (m_on) begin m_row = (m_row == NR - 1) ? 0 : m_row + 1; m_col = 0; end
    end else if (w) begin
      if (m_on && m_col < NC) begin
        m_lvl[m_row * NC + m_col] = data % 16;
        m_col++;
      end
    end
  endfunction

  task automatic drive(input bit s, input int dev, input bit n,
                       input bit w, input int data);
    sel_valid = s; sel_dev = 8'(dev); nl_valid = n; wr_valid = w; wr_data = 8'(data);
    model_step(s, dev, n, w, data);
    @(negedge clk);
    sel_valid = 1'b0; nl_valid = 1'b0; wr_valid = 1'b0;
  endtask

  task automatic do_sel(input int dev); drive(1, dev, 0, 0, 0); endtask
  task automatic do_nl();               drive(0, 0, 1, 0, 0);   endtask
  task automatic do_wr(input int data); drive(0, 0, 0, 1, data); endtask

  // measure every light over 16 cycles and compare its duty to the model
  task automatic check_all(input string tag);
    int cnt [NCELL];
    repeat (2) @(negedge clk);
    for (int i = 0; i < NCELL; i++) cnt[i] = 0;
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < NCELL; i++) if (lights[i]) cnt[i]++;
      @(negedge clk);
    end
    for (int i = 0; i < NCELL; i++) begin
      checks++;
      if (cnt[i] != duty_of(m_lvl[i])) begin
        errors++;
        $display("FAIL %s cell %0d duty actual %0d expected %0d",
                 tag, i, cnt[i], duty_of(m_lvl[i]));
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7331));
    for (int i = 0; i < NCELL; i++) m_lvl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: dark after reset, and writes before any select are ignored
    check_all("R1");
    do_wr(8'h0F); do_nl(); do_wr(8'h0A);
    check_all("R1");

    // R2 R3: select, write a line with noisy high nibbles; R7 extremes 0 and 15
    do_sel(MY_DEV);
    do_wr(8'hF0); do_wr(8'h3F); do_wr(8'hA7); do_wr(8'h51); do_wr(8'hC8);
    check_all("R3");
    checks++;
    if (m_lvl[0] != 0 || m_lvl[1] != 15) begin
      errors++;
      $display("FAIL R7 model setup actual %0d/%0d expected 0/15", m_lvl[0], m_lvl[1]);
    end
    check_all("R7");

    // R5: extra writes on a full line are dropped
    do_wr(8'h09); do_wr(8'h0E);
    check_all("R5");

    // R4: next line, then five more next-lines return to the same line
    do_nl(); do_wr(8'h06); do_wr(8'h02);
    repeat (5) do_nl();
    do_wr(8'h0D);
    check_all("R4");
    repeat (3) do_nl();
    do_wr(8'h04);
    do_nl(); do_wr(8'h0B);
    check_all("R4");

    // R6: another device, writes and next-lines ignored, picture kept
    do_sel(2);
    do_wr(8'h0F); do_nl(); do_wr(8'h0F);
    check_all("R6");
    // R2: reselect homes the cursor to line 0 column 0
    do_sel(MY_DEV);
    do_wr(8'h0C);
    check_all("R2");
    do_sel(MY_DEV);
    do_wr(8'h05);
    check_all("R2");

    // R8: coincident strobes
    drive(1, MY_DEV, 1, 1, 8'h0E);
    do_wr(8'h01);
    drive(0, 0, 1, 1, 8'h0F);
    do_wr(8'h08);
    drive(1, 4, 0, 1, 8'h0F);
    do_wr(8'h0F);
    check_all("R8");

    // random mix
    for (int r = 0; r < 10; r++) begin
      for (int k = 0; k < 80; k++) begin
        int p = int'($urandom_range(99));
        if (p < 6)       do_sel((p < 5) ? MY_DEV : int'($urandom_range(7)));
        else if (p < 22) do_nl();
        else if (p < 28) drive(bit'($urandom_range(1)), MY_DEV, 1'b1, 1'b1,
                               int'($urandom_range(255)));
        else             do_wr(int'($urandom_range(255)));
      end
      check_all("R3");
    end

    finish_run();
  end

endmodule